// File: doc/BRIEF.md
# Write-Only Control Register Loader over I2C

This block is an I2C target that only accepts writes. It loads a bank of nine 8-bit control registers, and the register outputs drive the switches and gain settings of an audio signal path. The target answers to one fixed 7-bit address. It acknowledges the address byte and every byte that follows it in the same transfer. The block runs on a system clock that is much faster than SCL. Both bus lines pass through two-flop synchronisers, and START and STOP are detected from SDA edges while SCL is high.

The first byte after the address is a command byte, and its two top bits select how the transfer is used. Two codes carry a 6-bit payload into the low bits of register 0 or register 1 in that single byte. One code sets a register pointer for the bytes that follow. The last code is reserved and writes nothing. In every mode, each later byte of the transfer is written whole to the next register index. Indices beyond the last register are skipped but still acknowledged.

Top module: `ctl_bank_i2c_slave`

## Requirements
- R1: The block acknowledges an address byte only when its upper seven bits equal 7'b1000000 and its R/W bit (bit 0) is 0. Any other address byte is not acknowledged, and the rest of that transfer has no effect on the registers.
- R2: After an accepted address, every byte of the transfer is acknowledged by pulling SDA low during the ninth SCL pulse. This includes command bytes in any mode and data bytes aimed past the last register.
- R3: A command byte with bits [7:6] = 2'b00 copies its bits [5:0] into bits [5:0] of register 0. Bits [7:6] of register 0 keep their old value.
- R4: A command byte with bits [7:6] = 2'b01 copies its bits [5:0] into bits [5:0] of register 1. Bits [7:6] of register 1 keep their old value.
- R5: A command byte with bits [7:6] = 2'b10 sets the pointer to its bits [3:0], and bits [5:4] have no effect. The next data byte is written whole to the register at that index.
- R6: A command byte with bits [7:6] = 2'b11 writes no register, and neither do the data bytes that follow it in the same transfer.
- R7: Each data byte advances the pointer by one. After a 2'b00 command the first data byte goes whole to register 1. After a 2'b01 command it goes whole to register 2.
- R8: A data byte whose pointer is above 8 writes nothing. This covers a pointer value from 9 to 15, and a pointer that has advanced past register 8.
- R9: A synchronous reset clears all nine registers to zero. Output bits [8k+7:8k] carry register k at all times.
- R10: SDA is pulled low only as an acknowledge, and the pull starts while SCL is low. It is released when SCL falls at the end of the ninth pulse, and also on START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must be much faster than SCL |
| rst | input | 1 | Synchronous reset, active high |
| scl_in | input | 1 | SCL line level, asynchronous |
| sda_in | input | 1 | SDA line level, asynchronous |
| sda_pull | output | 1 | 1 = drive SDA low (open-drain enable) |
| ctl_regs | output | 72 | Register contents; register k in bits [8k+7:8k] |

## Verification
The assertions assume a well-formed controller: SDA changes only while SCL is low, except to form START or STOP. Each SCL level lasts several system clocks, so that every edge survives synchronisation. They also assume the controller releases SDA during each acknowledge pulse. The bench keeps SDA stable for ten clocks on either side of each SCL edge and drives the line as open drain, wired-AND with the block's pull. It also ends every transfer with a proper STOP, including transfers whose address was refused.

// File: rtl/ctl_bank_i2c_slave.sv
module ctl_bank_i2c_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1000000,
  parameter int NREG = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_in,
  input  logic            sda_in,
  output logic            sda_pull,
  output logic [NREG*8-1:0] ctl_regs
);
  localparam int PW = $clog2(NREG) + 1;
  localparam logic [PW-1:0] LAST = PW'(NREG - 1);
  localparam logic [PW-1:0] PMAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_RECV, S_ACK} st_t;
  typedef enum logic [1:0] {P_ADDR, P_CMD, P_DATA} ph_t;

  logic [2:0] scl_q, sda_q;
  logic scl_s, scl_d, sda_s, sda_d;
  st_t st;
  ph_t ph;
  logic [3:0] bit_n;
  logic [7:0] sh;
  logic [PW-1:0] ptr;
  logic [7:0] bank [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  assign scl_s = scl_q[1];
  assign scl_d = scl_q[2];
  assign sda_s = sda_q[1];
  assign sda_d = sda_q[2];

  wire start_c  = scl_s & scl_d & sda_d & ~sda_s;
  wire stop_c   = scl_s & scl_d & ~sda_d & sda_s;
  wire scl_rise = scl_s & ~scl_d;
  wire scl_fall = ~scl_s & scl_d;

  wire byte_done = (st == S_RECV) && scl_fall && (bit_n == 4'd8);
  wire addr_ok   = (sh[7:1] == DEV_ADDR) && !sh[0];
  wire wr_cmd    = byte_done && (ph == P_CMD);
  wire wr_data   = byte_done && (ph == P_DATA) && (ptr <= LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      ph <= P_ADDR;
      bit_n <= '0;
      sh <= '0;
      sda_pull <= 1'b0;
    end else if (start_c) begin
      st <= S_RECV;
      ph <= P_ADDR;
      bit_n <= '0;
      sda_pull <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE;
      sda_pull <= 1'b0;
    end else begin
      case (st)
        S_RECV: begin
          if (scl_rise && bit_n < 4'd8) begin
            sh <= {sh[6:0], sda_s};
            bit_n <= bit_n + 4'd1;
          end
          if (byte_done) begin
            if (ph == P_ADDR && !addr_ok) begin
              st <= S_IDLE;
            end else begin
              st <= S_ACK;
              sda_pull <= 1'b1;
              ph <= (ph == P_ADDR) ? P_CMD : P_DATA;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            sda_pull <= 1'b0;
            st <= S_RECV;
            bit_n <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else if (wr_cmd) begin
      case (sh[7:6])
        2'b00: begin bank[0][5:0] <= sh[5:0]; ptr <= PW'(1); end
        2'b01: begin bank[1][5:0] <= sh[5:0]; ptr <= PW'(2); end
        2'b10: ptr <= PW'(sh[3:0]);
        default: ptr <= PMAX;
      endcase
    end else if (byte_done && ph == P_DATA) begin
      if (wr_data) bank[ptr] <= sh;
      if (ptr != PMAX) ptr <= ptr + 1'b1;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign ctl_regs[g*8 +: 8] = bank[g];
  end

  a_r1_reject_addr: assert property (@(posedge clk) disable iff (rst)
    (byte_done && ph == P_ADDR && !addr_ok && !start_c && !stop_c) |=> (!sda_pull && st == S_IDLE));
  a_r3_quick_keeps_top: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && sh[7:6] == 2'b00 && !start_c && !stop_c) |=>
      (bank[0][7:6] == $past(bank[0][7:6]) && bank[0][5:0] == $past(sh[5:0])));
  a_r6_test_no_write: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && sh[7:6] == 2'b11) |=> $stable(ctl_regs));
  a_r8_no_oob_write: assert property (@(posedge clk) disable iff (rst)
    (byte_done && ph == P_DATA && ptr > LAST) |=> $stable(ctl_regs));
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (ctl_regs == '0));
  a_r10_pull_on_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_pull) |-> !scl_s);
endmodule

// File: tb/test_ctl_bank_i2c_slave.sv
module test_ctl_bank_i2c_slave;
  localparam int Q = 10;
  logic clk = 0, rst = 1;
  logic scl_m = 1, sda_m = 1;
  logic sda_pull;
  logic [71:0] ctl_regs;
  wire sda_line = sda_m & ~sda_pull;

  ctl_bank_i2c_slave i_ctl_bank_i2c_slave (
    .clk(clk), .rst(rst), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .ctl_regs(ctl_regs));

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic cmp_en = 0;
  string cur_req = "R9";
  logic [7:0] mdl [9];
  int mptr;
  logic [7:0] txq [$];

  task automatic chk(input logic ok, input string req, input logic [71:0] act, input logic [71:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [71:0] mdl_flat();
    logic [71:0] v;
    for (int i = 0; i < 9; i++) v[i*8 +: 8] = mdl[i];
    return v;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cmp_en) chk(ctl_regs == mdl_flat(), cur_req, ctl_regs, mdl_flat());
    if (cyc > 190000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<190000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic w(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1; scl_m = 1; w(Q);
    sda_m = 0; w(Q);
    scl_m = 0; w(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; w(Q);
    scl_m = 1; w(Q);
    sda_m = 1; w(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    logic got;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(Q);
      scl_m = 1; w(2*Q);
      chk(!sda_pull, "R10", {71'd0, sda_pull}, 72'd0);
      scl_m = 0; w(Q);
    end
    sda_m = 1; w(Q);
    scl_m = 1; w(Q);
    got = ~sda_line;
    w(Q);
    scl_m = 0; w(Q);
    chk(got == exp_ack, req, {71'd0, got}, {71'd0, exp_ack});
  endtask

  task automatic xfer(input logic [7:0] addr, input string req);
    logic acc;
    cmp_en = 0;
    cur_req = req;
    acc = (addr == 8'h80);
    bus_start();
    send_byte(addr, acc, "R1");
    if (acc) begin
      for (int i = 0; i < txq.size(); i++) begin
        send_byte(txq[i], 1'b1, "R2");
        if (i == 0) begin
          case (txq[0][7:6])
            2'b00: begin mdl[0][5:0] = txq[0][5:0]; mptr = 1; end
            2'b01: begin mdl[1][5:0] = txq[0][5:0]; mptr = 2; end
            2'b10: mptr = int'(txq[0][3:0]);
            default: mptr = 99;
          endcase
        end else begin
          if (mptr <= 8) mdl[mptr] = txq[i];
          mptr++;
        end
      end
    end
    bus_stop();
    w(8);
    chk(ctl_regs == mdl_flat(), req, ctl_regs, mdl_flat());
    cmp_en = 1;
    w(20);
    txq.delete();
  endtask

  initial begin
    for (int i = 0; i < 9; i++) mdl[i] = 8'h00;
    w(5);
    rst = 0;
    w(5);
    chk(ctl_regs == 72'd0, "R9", ctl_regs, 72'd0);
    cmp_en = 1;

    // R5 R7: pointer to R3, three bytes
    txq = '{8'h83, 8'hA1, 8'h5B, 8'hC7};
    xfer(8'h80, "R5");
    // R5: bits [5:4] ignored -> R2
    txq = '{8'hB2, 8'h3C};
    xfer(8'h80, "R5");
    // fill R0, R1 fully, then quick loads
    txq = '{8'h80, 8'hFF, 8'hFF, 8'hFF};
    xfer(8'h80, "R7");
    txq = '{8'h15};
    xfer(8'h80, "R3");
    txq = '{8'h2A, 8'h96};
    xfer(8'h80, "R3");
    txq = '{8'h40, 8'h69};
    xfer(8'h80, "R4");
    txq = '{8'h7F, 8'h00, 8'h11};
    xfer(8'h80, "R4");
    // R6: test mode, no writes
    txq = '{8'hC0, 8'hEE, 8'hDD, 8'hCC};
    xfer(8'h80, "R6");
    txq = '{8'hFF, 8'h12};
    xfer(8'h80, "R6");
    // R8: pointer above 8, and running past R8
    txq = '{8'h89, 8'h77, 8'h66};
    xfer(8'h80, "R8");
    txq = '{8'h8F, 8'h55};
    xfer(8'h80, "R8");
    txq = '{8'h87, 8'h9A, 8'hBC, 8'hDE, 8'hF0};
    xfer(8'h80, "R8");
    // R1: wrong address and read bit
    txq = '{8'h80, 8'h00};
    xfer(8'h82, "R1");
    xfer(8'h81, "R1");
    xfer(8'h00, "R1");
    // R9: synchronous reset clears the bank
    cmp_en = 0;
    rst = 1; w(2);
    rst = 0;
    for (int i = 0; i < 9; i++) mdl[i] = 8'h00;
    w(2);
    chk(ctl_regs == 72'd0, "R9", ctl_regs, 72'd0);
    cur_req = "R9";
    cmp_en = 1;
    txq = '{8'h88, 8'h3E};
    xfer(8'h80, "R5");
    w(10);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule